// File: doc/BRIEF.md
# Programmable PWM edge timing generator

The block produces a single pulse-width-modulated output inside a repeating switching period. The period is counted in fine ticks of one clock each (one tick stands for 5 ns). The period length comes from a dedicated input. The switching period is also divided into coarse steps of eight ticks each (40 ns).

The rising and falling edge positions are 12-bit tick counts. Each is written as two byte-wide register fields: a high byte, plus a control byte whose upper nibble carries the low four bits. The control byte also holds a modulation-enable bit and a direction bit. An external signed modulation word can therefore push either edge later or earlier, and the shifted edge saturates inside the period.

When both edges land in the same coarse step, the pulse is dropped for the whole period. Register writes, the period input and the modulation word are captured only at the start of a period, so a period never runs on half-updated settings. A one-cycle sync output marks tick 0 of every period.

Top module: `pwm_edge_gen`

## Requirements
- R1: While `rst_ni` is low, `pwm_o` and `sync_o` are both 0.
- R2: The period is `period_i` ticks, with `period_i` of 2 or more. `sync_o` is 1 for exactly one cycle at tick 0, and successive `sync_o` pulses are `period_i` cycles apart.
- R3: An edge time is `{high byte, control[7:4]}` in ticks. The rising edge is at register address 0 (high byte) and 1 (control). The falling edge is at address 2 (high byte) and 3 (control). Without modulation, `pwm_o` is 1 exactly for ticks t with rise <= t < fall.
- R4: If rise/8 equals fall/8 (same coarse step), `pwm_o` stays 0 for the whole period. Edges in adjacent steps, even one tick apart, give a pulse.
- R5: If fall <= rise and the two edges are in different coarse steps, `pwm_o` stays 0 for the whole period.
- R6: When control bit 1 (modulation enable) of an edge is 0, `mod_i` does not move that edge.
- R7: When control bit 1 is 1, the effective edge is base + `mod_i` if control bit 0 is 0, and base − `mod_i` if control bit 0 is 1. `mod_i` is two's complement.
- R8: Each effective edge saturates to the range 0 to `period_i`−1. `pwm_o` is therefore 0 on the last tick of every period, and the widest pulse is `period_i`−1 ticks.
- R9: Register writes and changes of `period_i` and `mod_i` during a period do not affect that period. They take effect from the next tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, one cycle per fine tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0/1 rise high/control, 2/3 fall high/control) |
| wr_data_i | input | 8 | Register write data |
| period_i | input | 12 | Switching period length in ticks |
| mod_i | input | 8 | Signed modulation word |
| pwm_o | output | 1 | PWM output |
| sync_o | output | 1 | High on tick 0 of each period |

## Verification
A wrong counter or period capture shows at once as a `sync_o` spacing that differs from the programmed period, within one period of the change. Errors in edge assembly, direction handling or saturation show as a pulse that starts at the wrong tick or has the wrong width, measured over the first full period after the setting is loaded. A broken shadow shows in the period during which new values are written: its pulse no longer matches the settings that were loaded at its start. The coarse-step suppression and the final-tick-low rule show as a pulse present, or absent, where the opposite is expected.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  localparam int T_W       = 12;
  localparam int DATA_W    = 8;
  localparam int LO_W      = T_W - DATA_W;
  localparam int MOD_W     = 8;
  localparam int COARSE_SH = 3;
  localparam int NUM_EDGES = 2;
  localparam int ADDR_W    = $clog2(NUM_EDGES) + 1;
  localparam int EXT_W     = T_W + 2;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic           en;
    logic           sgn;
  } edge_cfg_t;

  // join a high byte and a control byte into one edge setting
  function automatic edge_cfg_t assemble(logic [DATA_W-1:0] hi, logic [DATA_W-1:0] ctl);
    edge_cfg_t c;
    c.t   = {hi, ctl[DATA_W-1 -: LO_W]};
    c.en  = ctl[1];
    c.sgn = ctl[0];
    return c;
  endfunction

  // modulated edge, clamped to 0 .. per-1
  function automatic logic [T_W-1:0] edge_mod(edge_cfg_t c, logic signed [MOD_W-1:0] m,
                                              logic [T_W-1:0] per);
    localparam logic signed [EXT_W-1:0] ONE_S = 1;
    logic signed [EXT_W-1:0] v, d, top;
    d = {{(EXT_W-MOD_W){m[MOD_W-1]}}, m};
    v = {2'b00, c.t};
    if (c.en) v = c.sgn ? (v - d) : (v + d);
    top = (per == '0) ? '0 : ({2'b00, per} - ONE_S);
    if (v[EXT_W-1])   return '0;
    else if (v > top) return top[T_W-1:0];
    else              return v[T_W-1:0];
  endfunction

  function automatic logic same_step(logic [T_W-1:0] a, logic [T_W-1:0] b);
    return a[T_W-1:COARSE_SH] == b[T_W-1:COARSE_SH];
  endfunction
endpackage

// File: rtl/pwm_edge_regs.sv
module pwm_edge_regs
  import pwm_edge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output edge_cfg_t         cfg_o [NUM_EDGES]
);
  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
    logic [DATA_W-1:0] hi_q, ctl_q;
    logic hit_hi, hit_ctl;
    assign hit_hi  = wr_en_i && (wr_addr_i == ADDR_W'(2*e));
    assign hit_ctl = wr_en_i && (wr_addr_i == ADDR_W'(2*e+1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q  <= '0;
        ctl_q <= '0;
      end else begin
        if (hit_hi)  hi_q  <= wr_data_i;
        if (hit_ctl) ctl_q <= wr_data_i;
      end
    end

    assign cfg_o[e] = assemble(hi_q, ctl_q);
  end
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt
  import pwm_edge_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [T_W-1:0] period_i,
  output logic [T_W-1:0] cnt_o,
  output logic [T_W-1:0] per_o,
  output logic           run_o,
  output logic           load_o,
  output logic           sync_o
);
  localparam logic [T_W:0]   ONE_X = 1;
  localparam logic [T_W-1:0] ONE_T = 1;

  logic [T_W-1:0] cnt_q, per_q;
  logic           run_q;
  logic           last_tick;

  assign last_tick = ({1'b0, cnt_q} + ONE_X) >= {1'b0, per_q};
  assign load_o    = !run_q || last_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      run_q <= 1'b0;
    end else if (load_o) begin
      cnt_q <= '0;
      per_q <= period_i;
      run_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + ONE_T;
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign run_o  = run_q;
  assign sync_o = run_q && (cnt_q == '0);

  // R2: the tick count never reaches the loaded period
  assert_cnt_in_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && per_q != '0) |-> (cnt_q < per_q));

  // R2: the count advances by one between loads
  assert_cnt_steps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !load_o) |=> (cnt_q == $past(cnt_q) + ONE_T));
endmodule

// File: rtl/pwm_edge_calc.sv
module pwm_edge_calc
  import pwm_edge_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  edge_cfg_t               cfg_i,
  input  logic signed [MOD_W-1:0] mod_i,
  input  logic [T_W-1:0]          period_i,
  output logic [T_W-1:0]          eff_o
);
  logic [T_W-1:0] eff_q, eff_d;

  assign eff_d = edge_mod(cfg_i, mod_i, period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     eff_q <= '0;
    else if (load_i) eff_q <= eff_d;
  end

  assign eff_o = eff_q;

  // R9: the edge used in a period holds until the next period start
  assert_hold_between_loads_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(eff_q));
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_edge_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [T_W-1:0]          period_i,
  input  logic signed [MOD_W-1:0] mod_i,
  output logic                    pwm_o,
  output logic                    sync_o
);
  localparam logic [T_W-1:0] ONE_T = 1;

  edge_cfg_t      cfg [NUM_EDGES];
  logic [T_W-1:0] eff [NUM_EDGES];
  logic [T_W-1:0] cnt, per;
  logic           run, load;
  logic [T_W-1:0] rise_t, fall_t;
  logic           step_clash, in_window;

  pwm_edge_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .cfg_o(cfg)
  );

  pwm_period_cnt u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i),
    .cnt_o(cnt), .per_o(per), .run_o(run), .load_o(load), .sync_o(sync_o)
  );

  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_calc
    pwm_edge_calc u_calc (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .cfg_i(cfg[e]),
      .mod_i(mod_i), .period_i(period_i), .eff_o(eff[e])
    );
  end

  assign rise_t     = eff[0];
  assign fall_t     = eff[1];
  assign step_clash = same_step(rise_t, fall_t);
  assign in_window  = (cnt >= rise_t) && (cnt < fall_t);
  assign pwm_o      = run && !step_clash && in_window;

  // R3: a pulse begins only on the programmed rising tick
  assert_rise_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> (cnt == rise_t));

  // R4: edges sharing a coarse step never give a pulse
  assert_same_step_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_t[T_W-1:COARSE_SH] == fall_t[T_W-1:COARSE_SH]) |-> !pwm_o);

  // R8: the last tick of every period is low
  assert_last_tick_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && per != '0 && (cnt + ONE_T) == per) |-> !pwm_o);

  // R8: loaded edges lie inside the loaded period
  assert_edges_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && per != '0) |-> (rise_t < per && fall_t < per));
endmodule

// File: tb/pwm_edge_gen_tb_top.sv
module pwm_edge_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [11:0] period_i = 12'd64;
  logic signed [7:0] mod_i = '0;
  logic        pwm_o, sync_o;

  always #4 clk = ~clk;

  pwm_edge_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .period_i(period_i), .mod_i(mod_i),
    .pwm_o(pwm_o), .sync_o(sync_o)
  );

  typedef struct { int per; int rise; int width; string tag; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int eff(int base, bit en, bit sg, int m, int per);
    int v = base;
    if (en) v = sg ? base - m : base + m;
    if (v < 0) v = 0;
    if (v > per - 1) v = per - 1;
    return v;
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 2'(a); wr_data_i = 8'(d);
  endtask

  task automatic wait_sync();
    do @(negedge clk); while (!sync_o);
  endtask

  task automatic program_edges(int rb, bit ren, bit rsg, int fb, bit fen, bit fsg,
                               int per, int m, string tag);
    exp_t x;
    int r, f;
    wait_sync();
    wr(0, rb >> 4);
    wr(1, ((rb & 15) << 4) | (int'(ren) << 1) | int'(rsg));
    wr(2, fb >> 4);
    wr(3, ((fb & 15) << 4) | (int'(fen) << 1) | int'(fsg));
    @(negedge clk);
    wr_en_i = 1'b0;
    period_i = 12'(per);
    mod_i = 8'(m);
    r = eff(rb, ren, rsg, m, per);
    f = eff(fb, fen, fsg, m, per);
    x.per = per; x.tag = tag;
    if ((r >> 3) == (f >> 3) || f <= r) begin x.rise = -1; x.width = 0; end
    else begin x.rise = r; x.width = f - r; end
    q.push_back(x);
  endtask

  // monitor: measures each period that has a pending expectation
  exp_t cur;
  bit   meas = 1'b0;
  int   idx, first, last, hi_cnt;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (sync_o) begin
        if (meas) begin
          check(idx == cur.per, cur.tag, "period length (R2)", idx, cur.per);
          check(first == cur.rise, cur.tag, "rising tick", first, cur.rise);
          check(hi_cnt == cur.width, cur.tag, "pulse width", hi_cnt, cur.width);
          check(hi_cnt == 0 || last - first + 1 == hi_cnt, cur.tag, "contiguous pulse",
                last - first + 1, hi_cnt);
          check(last != cur.per - 1, cur.tag, "last tick low (R8)", last, -1);
        end
        meas = 1'b0;
        if (q.size() > 0) begin
          cur = q.pop_front();
          meas = 1'b1; idx = 0; first = -1; last = -1; hi_cnt = 0;
        end
      end
      if (meas) begin
        if (pwm_o) begin
          if (first < 0) first = idx;
          last = idx;
          hi_cnt++;
        end
        idx++;
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(pwm_o == 1'b0, "R1", "pwm during reset", int'(pwm_o), 0);
      check(sync_o == 1'b0, "R1", "sync during reset", int'(sync_o), 0);
    end
    rst_ni = 1'b1;
    // R3 basic window
    program_edges(10, 0, 0, 50, 0, 0, 64, 0, "R3");
    // R9: these writes land during the R3 period; R2 period change
    program_edges(33, 0, 0, 90, 0, 0, 128, 0, "R9");
    // R4 same coarse step
    program_edges(17, 0, 0, 22, 0, 0, 40, 0, "R4");
    // R4 boundary: adjacent steps one tick apart
    program_edges(15, 0, 0, 16, 0, 0, 40, 0, "R4");
    // R5 fall before rise
    program_edges(50, 0, 0, 20, 0, 0, 64, 0, "R5");
    // R6 modulation disabled
    program_edges(8, 0, 1, 40, 0, 0, 64, 30, "R6");
    // R7 right move on rise, left move on fall
    program_edges(8, 1, 0, 40, 1, 1, 64, 6, "R7");
    // R7 negative word with sign 0 moves earlier
    program_edges(20, 1, 0, 48, 0, 0, 64, -4, "R7");
    // R8 clamp to 0 and to period-1, widest pulse
    program_edges(0, 1, 1, 4095, 0, 0, 64, 20, "R8");
    // R8 upper clamp makes both edges share the last step
    program_edges(60, 1, 0, 63, 0, 0, 64, 100, "R8");
    // R2 short period
    program_edges(2, 0, 0, 12, 0, 0, 16, 0, "R2");
    wait_sync();
    wait_sync();
    wait_sync();
    check(q.size() == 0 && !meas, "R2", "all periods measured", q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule